// File: doc/BRIEF.md
# Reference Divider, Phase-Frequency Detector and Unlock Mute

This block sits in the digital part of a frequency synthesizer loop. It counts a crystal reference clock down to the comparison rate with a fixed chain of one pre-stage and several equal stages. It then compares the falling edges of that rate with the falling edges of the divided oscillator pulse. A sequential phase-frequency detector turns the time between the two edges into an `up` or `down` request for an external charge pump.

The width of each request is measured in reference clocks. A request wider than a small limit marks the loop as out of lock. When that happens, `unlock` rises and the transmit oscillator amplifier enable `amp_en` drops on the same clock edge. The indicator clears on the next clean comparison. The amplifier comes back only after a run of consecutive clean comparisons. Short disturbances while the loop settles therefore show on `unlock` but cannot switch the amplifier on early. Recovery needs no outside action.

All logic runs on the reference clock. `vco_div` is sampled on that clock, so the divided oscillator pulse must be slower than the reference. With the defaults, a 5.12 MHz reference gives 10 kHz comparisons (ratio 2·16·16 = 512).

Top module: `synth_phase_guard`

## Requirements
- R1: A reference comparison edge occurs every PRE_DIV·STAGE_DIV^STAGES clocks. The first one falls on the clock edge numbered that ratio after reset is released (edge 512 by default), with edge 1 being the first edge seen with `rst_n` high.
- R2: When the reference edge comes d ≥ 1 clocks before the oscillator edge, `up` is high from the reference edge's clock edge until the oscillator edge's clock edge, which is exactly d cycles. `down` stays low during that time.
- R3: When the oscillator edge comes d ≥ 1 clocks before the reference edge, `down` is high for exactly d cycles in the same way. `up` stays low during that time.
- R4: A reference edge and an oscillator edge on the same clock edge, with no request pending, produce no `up` or `down` pulse at all.
- R5: An oscillator edge is a high sample of `vco_div` followed by a low sample on the next clock edge. Only this falling transition counts as an edge.
- R6: When a request stays open for more than LIMIT cycles (default 2), `unlock` rises on the clock edge LIMIT cycles after the request opened.
- R7: `unlock` clears on the clock edge where a comparison completes with a request width of at most LIMIT cycles. Coincident edges count as width 0.
- R8: `amp_en` falls on the same clock edge on which `unlock` rises. `amp_en` is never high while `unlock` is high.
- R9: `amp_en` rises on the clock edge that completes the CLEAN-th (default 16) consecutive clean comparison counted since the last unlock or since reset.
- R10: While `rst_n` is low, `up`, `down`, `unlock` and `amp_en` are all low. The divider and the clean-run count restart from zero.
- R11: Requests of 1 to LIMIT cycles count as clean. They neither raise `unlock` nor disturb `amp_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_div | input | 1 | Divided oscillator pulse, sampled on `clk` |
| up | output | 1 | Charge-pump request: raise the oscillator frequency |
| down | output | 1 | Charge-pump request: lower the oscillator frequency |
| unlock | output | 1 | Loop reported out of lock |
| amp_en | output | 1 | Transmit oscillator amplifier enable |

## Verification
On every cycle, the assertions check the spacing of reference edges, that `up` and `down` are never high together, that coincident edges yield no request, that an over-limit request has raised `unlock`, that a clean comparison clears it, that `amp_en` is low while `unlock` is high, and that every rise of `amp_en` directly follows a clean comparison. Only the bench scenarios can show the exact request widths for each phase offset, the edge on which `unlock` rises, and the count of clean periods needed before release. They also show that a later wide request restarts that count, and that requests just inside the limit leave the amplifier on. The bench does this by sweeping every offset across a quarter period on a reduced divider.

// File: rtl/synth_guard_pkg.sv
package synth_guard_pkg;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;

  // bits needed to hold values 0..maxval
  function automatic int width_for(input int maxval);
    int w;
    w = 1;
    while ((1 << w) <= maxval) w++;
    return w;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // total reference-to-comparison division ratio
  function automatic int cmp_ratio(input int pre, input int stage, input int stages);
    int r;
    r = pre;
    for (int i = 0; i < stages; i++) r = r * stage;
    return r;
  endfunction

endpackage

// File: rtl/synth_ref_divider.sv
module synth_ref_divider
  import synth_guard_pkg::*;
#(
  parameter int PRE_DIV   = 2,
  parameter int STAGE_DIV = 16,
  parameter int STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_evt
);
  localparam int NSTG = STAGES + 1;
  localparam int CW   = width_for(max_of(PRE_DIV, STAGE_DIV) - 1);

  logic [NSTG:0] carry;
  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int DIV = (g == 0) ? PRE_DIV : STAGE_DIV;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (carry[g]) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    assign carry[g+1] = carry[g] && (cnt_q == LAST);
  end

  // whole chain wrapping = falling edge of the comparison-rate wave
  assign ref_evt = carry[NSTG];
endmodule

// File: rtl/synth_edge_pfd.sv
module synth_edge_pfd
  import synth_guard_pkg::*;
#(
  parameter int LIMIT = 2,
  parameter int WW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_evt,
  input  logic          vco_div,
  output logic          up,
  output logic          dn,
  output logic          v_evt,
  output logic          cmp_done,
  output logic [WW-1:0] pulse_w,
  output logic [WW-1:0] w_nxt
);
  localparam logic [WW-1:0] W_TOP = WW'(LIMIT + 1);

  logic      v_prev_q;
  pump_req_t req_q, req_set, req_d;

  assign v_evt = v_prev_q && !vco_div;

  always_comb begin
    req_set.up = req_q.up | ref_evt;
    req_set.dn = req_q.dn | v_evt;
    cmp_done   = req_set.up & req_set.dn;
    req_d.up   = req_set.up & ~cmp_done;
    req_d.dn   = req_set.dn & ~cmp_done;
    if (req_d.up | req_d.dn)
      w_nxt = (pulse_w == W_TOP) ? W_TOP : pulse_w + 1'b1;
    else
      w_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_prev_q <= 1'b0;
      req_q    <= '0;
      pulse_w  <= '0;
    end else begin
      v_prev_q <= vco_div;
      req_q    <= req_d;
      pulse_w  <= w_nxt;
    end
  end

  assign up = req_q.up;
  assign dn = req_q.dn;
endmodule

// File: rtl/synth_lock_guard.sv
module synth_lock_guard
  import synth_guard_pkg::*;
#(
  parameter int LIMIT = 2,
  parameter int CLEAN = 16,
  parameter int WW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_done,
  input  logic [WW-1:0] pulse_w,
  input  logic [WW-1:0] w_nxt,
  output logic          cmp_clean,
  output logic          unlock,
  output logic          amp_en
);
  localparam int GW = width_for(CLEAN);
  localparam logic [WW-1:0] LIM_V   = WW'(LIMIT);
  localparam logic [GW-1:0] CLEAN_V = GW'(CLEAN);

  logic          wide;
  logic [GW-1:0] good_q, good_d;

  assign wide      = w_nxt > LIM_V;
  assign cmp_clean = cmp_done && (pulse_w <= LIM_V);

  always_comb begin
    if (wide)
      good_d = '0;
    else if (cmp_clean)
      good_d = (good_q == CLEAN_V) ? CLEAN_V : good_q + 1'b1;
    else
      good_d = good_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock <= 1'b0;
      good_q <= '0;
      amp_en <= 1'b0;
    end else begin
      if (wide)           unlock <= 1'b1;
      else if (cmp_clean) unlock <= 1'b0;
      good_q <= good_d;
      amp_en <= (good_d == CLEAN_V);
    end
  end
endmodule

// File: rtl/synth_phase_guard.sv
module synth_phase_guard
  import synth_guard_pkg::*;
#(
  parameter int PRE_DIV   = 2,
  parameter int STAGE_DIV = 16,
  parameter int STAGES    = 2,
  parameter int LIMIT     = 2,
  parameter int CLEAN     = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vco_div,
  output logic up,
  output logic down,
  output logic unlock,
  output logic amp_en
);
  localparam int WW = width_for(LIMIT + 1);

  logic          ref_evt;
  logic          v_evt;
  logic          cmp_done;
  logic          cmp_clean;
  logic [WW-1:0] pulse_w;
  logic [WW-1:0] w_nxt;

  synth_ref_divider #(
    .PRE_DIV(PRE_DIV), .STAGE_DIV(STAGE_DIV), .STAGES(STAGES)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt)
  );

  synth_edge_pfd #(.LIMIT(LIMIT), .WW(WW)) u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .vco_div(vco_div),
    .up(up), .dn(down), .v_evt(v_evt), .cmp_done(cmp_done),
    .pulse_w(pulse_w), .w_nxt(w_nxt)
  );

  synth_lock_guard #(.LIMIT(LIMIT), .CLEAN(CLEAN), .WW(WW)) u_guard (
    .clk(clk), .rst_n(rst_n), .cmp_done(cmp_done), .pulse_w(pulse_w),
    .w_nxt(w_nxt), .cmp_clean(cmp_clean), .unlock(unlock), .amp_en(amp_en)
  );
endmodule

// File: rtl/synth_phase_guard_chk.sv
module synth_phase_guard_chk
  import synth_guard_pkg::*;
#(
  parameter int PRE_DIV   = 2,
  parameter int STAGE_DIV = 16,
  parameter int STAGES    = 2,
  parameter int LIMIT     = 2,
  parameter int WW        = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_evt,
  input logic          v_evt,
  input logic          up,
  input logic          down,
  input logic [WW-1:0] pulse_w,
  input logic          cmp_clean,
  input logic          unlock,
  input logic          amp_en
);
  localparam int P  = cmp_ratio(PRE_DIV, STAGE_DIV, STAGES);
  localparam int PW = width_for(P);
  localparam logic [PW-1:0] P_LAST = PW'(P - 1);
  localparam logic [WW-1:0] LIM_V  = WW'(LIMIT);

  logic [PW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_q <= '0;
    else if (ref_evt) gap_q <= '0;
    else              gap_q <= gap_q + 1'b1;
  end

  // R1
  a_r1_ref_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ref_evt |-> (gap_q == P_LAST));
  // R2, R3
  a_r2_up_down_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && down));
  // R4
  a_r4_coincident_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_evt && v_evt && !up && !down) |=> (!up && !down));
  // R6
  a_r6_wide_sets_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_w > LIM_V) |-> unlock);
  // R7
  a_r7_clean_clears_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_clean |=> !unlock);
  // R8
  a_r8_mute_while_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |-> !amp_en);
  // R9
  a_r9_release_on_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_en) |-> $past(cmp_clean));
endmodule

bind synth_phase_guard synth_phase_guard_chk #(
  .PRE_DIV(PRE_DIV), .STAGE_DIV(STAGE_DIV), .STAGES(STAGES),
  .LIMIT(LIMIT), .WW(WW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_evt(ref_evt), .v_evt(v_evt),
  .up(up), .down(down), .pulse_w(pulse_w), .cmp_clean(cmp_clean),
  .unlock(unlock), .amp_en(amp_en)
);

// File: tb/synth_phase_guard_tb.sv
module synth_phase_guard_tb;
  localparam int P     = 32;   // 2 * 4 * 4
  localparam int LIM   = 2;
  localparam int CLEAN = 4;
  localparam int MAXP  = 160;
  localparam int VLOW  = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, vco_div;
  logic up, down, unlock, amp_en;
  logic f_up, f_down, f_unlock, f_amp;
  logic vhi;
  assign vhi = 1'b1;

  int offs [0:MAXP];
  int nper;
  int ec;
  int vectors, fails;
  bit done;

  synth_phase_guard #(.PRE_DIV(2), .STAGE_DIV(4), .STAGES(2),
                      .LIMIT(LIM), .CLEAN(CLEAN)) u_dut (
    .clk(clk), .rst_n(rst_n), .vco_div(vco_div),
    .up(up), .down(down), .unlock(unlock), .amp_en(amp_en));

  synth_phase_guard u_full (
    .clk(clk), .rst_n(rst_n), .vco_div(vhi),
    .up(f_up), .down(f_down), .unlock(f_unlock), .amp_en(f_amp));

  task automatic chk(input string req, input logic act, input logic exp, input int n);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: got %b expected %b", req, n, act, exp);
    end
  endtask

  task automatic add(input int o);
    nper++;
    offs[nper] = o;
  endtask

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // vco_div is low during VLOW edges starting at the oscillator edge of each period
  function automatic bit v_low(input int n);
    for (int k = 1; k <= nper; k++) begin
      int e;
      e = k * P + offs[k];
      if (n >= e && n < e + VLOW) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit exp_up(input int n);
    for (int k = 1; k <= nper; k++)
      if (offs[k] > 0 && n >= k * P && n < k * P + offs[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_dn(input int n);
    for (int k = 1; k <= nper; k++)
      if (offs[k] < 0 && n >= k * P + offs[k] && n < k * P) return 1'b1;
    return 1'b0;
  endfunction

  // unlock rises LIM edges after a wide request opens; a clean period
  // ends at its later edge; amp returns after CLEAN clean periods in a row
  task automatic exp_state(input int n, output bit unl, output bit amp);
    int g;
    unl = 1'b0;
    g = 0;
    for (int k = 1; k <= nper; k++) begin
      int a, s;
      a = abs_i(offs[k]);
      s = k * P - ((offs[k] < 0) ? a : 0);
      if (a > LIM) begin
        if (s + LIM <= n) begin unl = 1'b1; g = 0; end
      end else if (s + a <= n) begin
        unl = 1'b0;
        g++;
      end
    end
    amp = (g >= CLEAN);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit eu, ea;
    int last;
    vectors = 0; fails = 0; done = 1'b0; nper = 0;
    for (int i = 0; i <= MAXP; i++) offs[i] = 0;
    for (int i = 0; i < 6; i++) add(0);
    for (int o = -8; o <= 8; o++) begin
      add(o);
      for (int i = 0; i < 5; i++) add(0);
    end
    // wide request interrupts a clean run: count must restart (R9)
    add(3); add(0); add(0); add(0); add(5);
    for (int i = 0; i < 5; i++) add(0);
    // requests inside the limit keep the amplifier on (R11)
    add(1); add(-2); add(2); add(-1); add(2); add(0);
    last = nper * P + 12;

    rst_n = 1'b0;
    vco_div = 1'b1;
    ec = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 up in reset", up, 1'b0, 0);
    chk("R10 down in reset", down, 1'b0, 0);
    chk("R10 unlock in reset", unlock, 1'b0, 0);
    chk("R10 amp_en in reset", amp_en, 1'b0, 0);
    chk("R10 full amp_en in reset", f_amp, 1'b0, 0);
    rst_n = 1'b1;

    while (ec < last) begin
      vco_div = !v_low(ec + 1);
      @(posedge clk);
      ec++;
      @(negedge clk);
      chk("R2 R4 R5 up", up, exp_up(ec), ec);
      chk("R3 R4 R5 down", down, exp_dn(ec), ec);
      exp_state(ec, eu, ea);
      chk("R6 R7 R11 unlock", unlock, eu, ec);
      chk("R8 R9 R11 amp_en", amp_en, ea, ec);
      if (ec == 511) chk("R1 full up before ratio", f_up, 1'b0, ec);
      if (ec == 512) chk("R1 full up at ratio", f_up, 1'b1, ec);
      if (ec == 513) chk("R6 full unlock not yet", f_unlock, 1'b0, ec);
      if (ec == 514) chk("R6 full unlock after limit", f_unlock, 1'b1, ec);
      if (ec == 514) chk("R3 full down idle", f_down, 1'b0, ec);
    end

    rst_n = 1'b0;
    #1;
    chk("R10 up after reset", up, 1'b0, ec);
    chk("R10 amp_en after reset", amp_en, 1'b0, ec);
    chk("R10 full unlock after reset", f_unlock, 1'b0, ec);
    chk("R10 full up after reset", f_up, 1'b0, ec);
    @(negedge clk);
    chk("R10 unlock held in reset", unlock, 1'b0, ec);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule